// File: doc/BRIEF.md
# Clocked Serial Link with Echo Check

This block is the byte-level physical layer of a point-to-point synchronous serial link between two small portable units. On its transmit side it takes one byte at a time through a valid/ready handshake. For each byte it drives a bit clock and a forward data line, most significant bit first, with data changing while the clock is low. While that byte goes out, it samples a separate return line on its own rising clock edges. That line carries the byte the peer received one byte-time earlier. At the end of the byte the sampled word is compared with the byte sent before. Any difference raises a sticky error flag.

The receive side of the same block serves the peer's transfers. It synchronizes the incoming clock and data and latches a bit on each rising clock edge. It presents every completed byte as a one-cycle pulse. It then plays that byte back on its own echo line during the next byte, shifting on the peer's falling edges. Bit timing comes from a clock-enable tick: each clock half-period lasts a fixed number of ticks. After every byte a programmable gap, also counted in ticks, holds off the next byte so the far end has time to process it. The first byte of a transfer is marked by the caller. It has no predecessor, so its echo window is not checked.

Top module: `echoLinkPhy`

## Requirements
- R1: Each byte is sent on `sdoOut` most significant bit first, and the receive side assembles bits sampled on `sclkIn` in arrival order, so the first bit received lands in `rxData[7]`.
- R2: `sdoOut` changes only while `sclkOut` is low. It is set when a byte is accepted and updated at each falling clock edge, and it never changes while the clock is high.
- R3: `sclkOut` is high for exactly HALF_TICKS ticks per bit and low for HALF_TICKS ticks between rising edges inside a byte. It stays low whenever no byte is being shifted.
- R4: Out of reset `sdoOut` is high, `sclkOut` is low and `echoOut` is low. `sdoOut` returns high at the last falling edge of every byte.
- R5: The receive side drives each received byte on `echoOut`, most significant bit first. It starts at the falling clock edge that ends that byte and advances one bit at each falling edge of the following byte, so the sender samples the whole byte on its next eight rising edges.
- R6: The sender samples `echoIn` at each of its own rising edges. After the eighth rising edge of a byte it compares the eight samples, first sample as the most significant bit, with the byte accepted before it. A mismatch sets `echoErr`.
- R7: A byte accepted with `txFirst` high is not compared, whatever arrives on `echoIn` during it.
- R8: `echoErr` stays set until `errClr` is high for one cycle. It then reads low on the next cycle, unless a mismatch is detected in that same cycle, in which case the flag stays set.
- R9: A byte is accepted when `txValid` and `txReady` are both high. `txReady` is high when idle, low from acceptance until the last falling edge, and low for `gapLen` ticks after that edge; a `gapLen` of 0 gives no gap.
- R10: `rxValid` is a single-cycle pulse for each eight bits received and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock-enable tick that paces bit timing |
| gapLen | input | GAP_W | Inter-byte hold-off in ticks |
| txValid | input | 1 | Byte offered for transmission |
| txFirst | input | 1 | Offered byte opens a transfer (echo not checked) |
| txData | input | DATA_W | Byte to send |
| txReady | output | 1 | Transmitter can accept a byte |
| errClr | input | 1 | Clears the echo-error flag |
| echoErr | output | 1 | Sticky echo-mismatch flag |
| sclkOut | output | 1 | Bit clock driven to the peer |
| sdoOut | output | 1 | Forward data to the peer |
| echoIn | input | 1 | Echo returned by the peer |
| sclkIn | input | 1 | Bit clock from the peer |
| sdiIn | input | 1 | Forward data from the peer |
| echoOut | output | 1 | Echo driven back to the peer |
| rxValid | output | 1 | Received byte strobe |
| rxData | output | DATA_W | Received byte |

## Verification
The bench loops the block back on itself. It sweeps all 256 byte values in transfers using gaps of zero, one and three ticks. It rebuilds each byte from the forward line and from the echo line at the rising edges. A design that shifted least significant bit first, or moved the echo by one bit, would return a permuted byte and fail here. It would also raise a false mismatch. The bench inverts the echo path during a first byte, where a design that checked it anyway would set the error. It inverts it again during a later byte, where a design that missed the comparison would stay clean. It also confirms that the error survives later good bytes and falls only on a clear. The gap is measured in cycles from the last falling edge to the return of ready, so an off-by-one tick count in the gap counter shows up directly.

// File: rtl/linkPkg.sv
package linkPkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_GAP  = 2'd3
  } txPhase_e;

  // strobes from transmit control to transmit datapath
  typedef struct packed {
    logic load;     // byte accepted this cycle
    logic rise;     // raise bit clock, sample echo
    logic fall;     // lower bit clock, advance data
    logic lastBit;  // current bit is the last of the byte
    logic busy;     // clock is being toggled for a byte
  } txStrobe_t;

endpackage

// File: rtl/linkSync.sv
module linkSync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= RST_VAL;
        else       chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/linkTxCtrl.sv
module linkTxCtrl
  import linkPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HALF_TICKS = 2,
  parameter int GAP_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             txValid,
  input  logic [GAP_W-1:0] gapLen,
  output logic             txReady,
  output txStrobe_t        strb
);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int HALF_W = $clog2(HALF_TICKS + 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(DATA_W - 1);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF_TICKS - 1);

  txPhase_e          phase;
  logic [BIT_W-1:0]  bitCnt;
  logic [HALF_W-1:0] halfCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic              halfDone;

  assign halfDone     = tick && (halfCnt == HALF_LAST);
  assign txReady      = (phase == PH_IDLE);
  assign strb.load    = txValid && (phase == PH_IDLE);
  assign strb.rise    = (phase == PH_LOW) && halfDone;
  assign strb.fall    = (phase == PH_HIGH) && halfDone;
  assign strb.lastBit = (bitCnt == BIT_LAST);
  assign strb.busy    = (phase == PH_LOW) || (phase == PH_HIGH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      halfCnt <= '0;
      gapCnt  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (strb.load) begin
            phase   <= PH_LOW;
            bitCnt  <= '0;
            halfCnt <= '0;
          end
        end
        PH_LOW: begin
          if (tick) begin
            if (halfDone) begin
              halfCnt <= '0;
              phase   <= PH_HIGH;
            end else begin
              halfCnt <= halfCnt + 1'b1;
            end
          end
        end
        PH_HIGH: begin
          if (tick) begin
            if (halfDone) begin
              halfCnt <= '0;
              if (strb.lastBit) begin
                bitCnt <= '0;
                gapCnt <= '0;
                phase  <= (gapLen == '0) ? PH_IDLE : PH_GAP;
              end else begin
                bitCnt <= bitCnt + 1'b1;
                phase  <= PH_LOW;
              end
            end else begin
              halfCnt <= halfCnt + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (gapCnt == gapLen - 1'b1) phase <= PH_IDLE;
            else                         gapCnt <= gapCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R3
  edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rise || strb.fall) |-> tick);

  // R9
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |-> !txReady);

endmodule

// File: rtl/linkTxPath.sv
module linkTxPath
  import linkPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              txFirst,
  input  logic              echoIn,
  input  logic              errClr,
  output logic              sclkOut,
  output logic              sdoOut,
  output logic              echoErr
);
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] curByte;
  logic [DATA_W-1:0] prevByte;
  logic [DATA_W-1:0] echoCap;
  logic [DATA_W-1:0] echoWord;
  logic              chkEn;
  logic              echoS;
  logic              mismatch;

  linkSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_echoSync (
    .clk (clk),
    .rstN(rstN),
    .d   (echoIn),
    .q   (echoS)
  );

  assign echoWord = {echoCap[DATA_W-2:0], echoS};
  assign mismatch = chkEn && strb.rise && strb.lastBit && (echoWord != prevByte);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      curByte  <= '0;
      prevByte <= '0;
      echoCap  <= '0;
      chkEn    <= 1'b0;
      sclkOut  <= 1'b0;
      sdoOut   <= 1'b1;
    end else begin
      if (strb.load) begin
        shReg    <= txData;
        sdoOut   <= txData[DATA_W-1];
        prevByte <= curByte;
        curByte  <= txData;
        chkEn    <= !txFirst;
      end
      if (strb.rise) begin
        sclkOut <= 1'b1;
        echoCap <= echoWord;
      end
      if (strb.fall) begin
        sclkOut <= 1'b0;
        if (strb.lastBit) begin
          sdoOut <= 1'b1;
        end else begin
          shReg  <= {shReg[DATA_W-2:0], 1'b0};
          sdoOut <= shReg[DATA_W-2];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         echoErr <= 1'b0;
    else if (mismatch) echoErr <= 1'b1;
    else if (errClr)   echoErr <= 1'b0;
  end

  // R3
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.busy |-> !sclkOut);

  // R4
  idle_data_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.busy |-> sdoOut);

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut |-> $stable(sdoOut));

  // R6
  err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(echoErr) |-> $past(strb.rise && strb.lastBit));

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !(strb.rise && strb.lastBit)) |=> !echoErr);

endmodule

// File: rtl/linkRx.sv
module linkRx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              sdiIn,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              echoOut
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic              sclkS, sdiS, sclkPrev;
  logic              riseS, fallS;
  logic [BIT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] echoReg;
  logic              pending;
  logic              echoLive;

  linkSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclkSync (
    .clk(clk), .rstN(rstN), .d(sclkIn), .q(sclkS)
  );
  linkSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sdiSync (
    .clk(clk), .rstN(rstN), .d(sdiIn), .q(sdiS)
  );

  assign riseS   = sclkS && !sclkPrev;
  assign fallS   = !sclkS && sclkPrev;
  assign echoOut = echoLive && echoReg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      bitCnt   <= '0;
      shReg    <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      pending  <= 1'b0;
      echoReg  <= '0;
      echoLive <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      rxValid  <= 1'b0;
      if (riseS) begin
        shReg <= {shReg[DATA_W-2:0], sdiS};
        if (bitCnt == BIT_LAST) begin
          bitCnt  <= '0;
          rxData  <= {shReg[DATA_W-2:0], sdiS};
          rxValid <= 1'b1;
          pending <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
      if (fallS) begin
        if (pending) begin
          echoReg  <= rxData;
          pending  <= 1'b0;
          echoLive <= 1'b1;
        end else begin
          echoReg <= {echoReg[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  // R10
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R5
  echo_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(echoOut) |-> $past(fallS));

endmodule

// File: rtl/echoLinkPhy.sv
module echoLinkPhy
  import linkPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_TICKS  = 2,
  parameter int GAP_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [GAP_W-1:0]  gapLen,
  input  logic              txValid,
  input  logic              txFirst,
  input  logic [DATA_W-1:0] txData,
  output logic              txReady,
  input  logic              errClr,
  output logic              echoErr,
  output logic              sclkOut,
  output logic              sdoOut,
  input  logic              echoIn,
  input  logic              sclkIn,
  input  logic              sdiIn,
  output logic              echoOut,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData
);
  txStrobe_t strb;

  linkTxCtrl #(.DATA_W(DATA_W), .HALF_TICKS(HALF_TICKS), .GAP_W(GAP_W)) u_txCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .txValid(txValid),
    .gapLen (gapLen),
    .txReady(txReady),
    .strb   (strb)
  );

  linkTxPath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_txPath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .txData (txData),
    .txFirst(txFirst),
    .echoIn (echoIn),
    .errClr (errClr),
    .sclkOut(sclkOut),
    .sdoOut (sdoOut),
    .echoErr(echoErr)
  );

  linkRx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk    (clk),
    .rstN   (rstN),
    .sclkIn (sclkIn),
    .sdiIn  (sdiIn),
    .rxValid(rxValid),
    .rxData (rxData),
    .echoOut(echoOut)
  );

endmodule

// File: tb/test_echoLinkPhy.sv
`timescale 1ns/1ps
module test_echoLinkPhy;
  localparam int DATA_W   = 8;
  localparam int HALF     = 2;
  localparam int GAP_W    = 4;
  localparam int TICK_DIV = 5;

  logic              clk = 1'b0;
  logic              rstN;
  logic              tick;
  logic [GAP_W-1:0]  gapLen;
  logic              txValid, txFirst;
  logic [DATA_W-1:0] txData;
  logic              txReady;
  logic              errClr;
  logic              echoErr;
  logic              sclkOut, sdoOut, echoOut, echoBack;
  logic              flipEcho;
  logic              rxValid;
  logic [DATA_W-1:0] rxData;

  assign echoBack = echoOut ^ flipEcho;

  echoLinkPhy #(.DATA_W(DATA_W), .HALF_TICKS(HALF), .GAP_W(GAP_W)) i_echoLinkPhy (
    .clk(clk), .rstN(rstN), .tick(tick), .gapLen(gapLen),
    .txValid(txValid), .txFirst(txFirst), .txData(txData), .txReady(txReady),
    .errClr(errClr), .echoErr(echoErr),
    .sclkOut(sclkOut), .sdoOut(sdoOut), .echoIn(echoBack),
    .sclkIn(sclkOut), .sdiIn(sdoOut), .echoOut(echoOut),
    .rxValid(rxValid), .rxData(rxData)
  );

  always #2.5 clk = ~clk;

  int nChk = 0, nFail = 0;
  bit done = 0;

  // monitor state
  int cyc = 0, riseCyc = 0, lastFallCyc = 0, falls = 0, riseIdx = 0;
  int widthBad = 0, sdoBad = 0, pulseBad = 0;
  logic [7:0] bitBuf = '0, echoBuf = '0, capSdo = '0, capEcho = '0, rxGot = '0;
  logic prevSclk = 1'b0, prevSdo = 1'b1, prevRxV = 1'b0;

  // expectations
  bit expErr = 0, havePrev = 0;
  logic [7:0] prevSent = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    tick = 1'b0;
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (sclkOut && !prevSclk) begin
        riseCyc = cyc;
        bitBuf  = {bitBuf[6:0], sdoOut};
        echoBuf = {echoBuf[6:0], echoOut};
        riseIdx++;
        if (riseIdx == 8) begin
          capSdo  = bitBuf;
          capEcho = echoBuf;
          riseIdx = 0;
        end
      end
      if (!sclkOut && prevSclk) begin
        if (cyc - riseCyc != HALF * TICK_DIV) widthBad++;
        lastFallCyc = cyc;
        falls++;
      end
      if (sclkOut && prevSclk && (sdoOut != prevSdo)) sdoBad++;
      if (rxValid) begin
        rxGot = rxData;
        if (prevRxV) pulseBad++;
      end
      prevRxV  = rxValid;
      prevSclk = sclkOut;
      prevSdo  = sdoOut;
    end
  end

  task automatic sendByte(input logic [7:0] b, input bit first, input bit flip, input int gap);
    int target;
    int gapCyc;
    @(negedge clk); #1;
    gapLen = GAP_W'(gap);
    while (!txReady) begin
      @(negedge clk); #1;
    end
    txValid  = 1'b1;
    txData   = b;
    txFirst  = first;
    flipEcho = flip;
    target   = falls + 8;
    @(negedge clk); #1;
    txValid = 1'b0;
    txFirst = 1'b0;
    while (falls < target) begin
      @(negedge clk); #1;
    end
    while (!txReady) begin
      @(negedge clk); #1;
    end
    flipEcho = 1'b0;
    gapCyc = cyc - lastFallCyc;
    if (flip && !first) expErr = 1;
    chk(capSdo == b, "R1 forward line order", capSdo, b);
    chk(rxGot == b, "R1 received byte", rxGot, b);
    if (havePrev) chk(capEcho == prevSent, "R5 echo of previous byte", capEcho, prevSent);
    chk(echoErr == expErr, "R6 R7 R8 echo error flag", echoErr, expErr);
    chk(gapCyc == gap * TICK_DIV, "R9 inter-byte gap", gapCyc, gap * TICK_DIV);
    prevSent = b;
    havePrev = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; gapLen = '0; txValid = 1'b0; txFirst = 1'b0; txData = '0;
    errClr = 1'b0; flipEcho = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    chk(sclkOut == 1'b0, "R4 clock low in reset", sclkOut, 0);
    chk(sdoOut == 1'b1, "R4 data high in reset", sdoOut, 1);
    chk(echoOut == 1'b0, "R4 echo low in reset", echoOut, 0);
    chk(echoErr == 1'b0, "R8 error clear in reset", echoErr, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(txReady == 1'b1, "R9 ready when idle", txReady, 1);
    chk(rxValid == 1'b0, "R10 no strobe when idle", rxValid, 0);
    chk(echoOut == 1'b0, "R4 echo low before any byte", echoOut, 0);

    // sweep all byte values, 16 transfers of 16 bytes, varying gap
    for (int t = 0; t < 16; t++) begin
      for (int i = 0; i < 16; i++) begin
        sendByte(8'(t * 16 + i), i == 0, 1'b0, (t % 3 == 0) ? 0 : ((t % 3 == 1) ? 1 : 3));
      end
    end

    // R7: corrupted echo during a first byte is ignored
    sendByte(8'hA5, 1'b1, 1'b1, 2);
    // R6: corrupted echo during a later byte is flagged
    sendByte(8'h5A, 1'b0, 1'b1, 2);
    // R8: flag survives good bytes
    sendByte(8'h3C, 1'b0, 1'b0, 2);
    sendByte(8'h81, 1'b0, 1'b0, 0);
    @(negedge clk); #1;
    errClr = 1'b1;
    @(negedge clk); #1;
    errClr = 1'b0;
    chk(echoErr == 1'b0, "R8 clear drops flag", echoErr, 0);
    expErr = 0;
    sendByte(8'hC3, 1'b0, 1'b0, 1);
    sendByte(8'hFF, 1'b0, 1'b0, 0);

    chk(widthBad == 0, "R3 clock high width", widthBad, 0);
    chk(sdoBad == 0, "R2 data stable while clock high", sdoBad, 0);
    chk(pulseBad == 0, "R10 single-cycle strobe", pulseBad, 0);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule